// File: doc/BRIEF.md
# Cursor Key Color Substitution Stage

This stage sits in a pixel stream. It looks at each incoming graphics word and tests whether that word equals a programmed cursor key value. A per-bit mask limits the test, and bits whose mask bit is zero take no part in the comparison. When the masked comparison matches, the stage drops the pixel and sends out one of two programmed cursor colors in its place. When it does not match, the pixel passes through unchanged.

The incoming pixel also chooses which replacement color is used. A 5-bit index names one bit of the pixel. If that bit is clear, the first color is used. If it is set, the second color is used. An index that points past the top bit of the pixel always selects the first color. The result is registered, so it appears one clock after the input, and its valid flag follows the input strobe.

Top module: `curkey_subst`

## Requirements
- R1: While synchronous reset `rst` is high, the output pixel and the output valid flag are zero on the next clock edge.
- R2: `pix_out_vld` equals `pix_in_vld` delayed by exactly one clock.
- R3: A pixel is a match when ((pixel XOR key) AND mask) is zero. A matching pixel is output as one of the two cursor colors one clock later.
- R4: A non-matching valid pixel is output unchanged one clock later.
- R5: Graphics bits whose mask bit is 0 do not affect the match. With an all-zero mask, every pixel is replaced.
- R6: On a match, if the pixel bit named by `bit_sel` (bit 0 is the LSB) is 0, the output is `color_a`. If that bit is 1, the output is `color_b`.
- R7: A `bit_sel` value of 24 or above (when the pixel is 24 bits wide) always selects `color_a`.
- R8: When `pix_in_vld` is low, the output pixel is zero one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 24 | Incoming graphics pixel |
| pix_in_vld | input | 1 | Input pixel valid |
| key_val | input | 24 | Cursor key value |
| key_mask | input | 24 | Compare mask, 1 = bit compared |
| bit_sel | input | 5 | Index of the pixel bit that picks the color |
| color_a | input | 24 | Replacement used when the selected bit is 0 |
| color_b | input | 24 | Replacement used when the selected bit is 1 |
| pix_out | output | 24 | Output pixel |
| pix_out_vld | output | 1 | Output valid |

## Verification
The bench targets the following cases:
- **Partial masks.** It uses masks in which only some bits are compared. A design that ignored the mask, or inverted its sense, would pass keyed pixels through or replace pixels that should have been left alone.
- **Selector bit.** It sweeps the selector across bit 0, bit 23 and a middle bit. A design with the index wrong by one position would pick the wrong color.
- **Out-of-range selector.** It uses selector values 24 and 31 with pixels whose high bits are set. A design that wrapped the index or truncated it would pick `color_b` there.
- **Valid gaps and reset.** It drops valid while a matching pixel is on the input, and it applies reset mid-stream. A design that leaked data without valid, or did not clear on reset, would show nonzero output.

// File: rtl/curkey_pkg.sv
package curkey_pkg;
   localparam int unsigned PIX_W_DEF = 24;
   localparam int unsigned SEL_W_DEF = 5;

   typedef enum logic [1:0] {
      SRC_PASS  = 2'd0,
      SRC_COL_A = 2'd1,
      SRC_COL_B = 2'd2
   } src_sel_e;
endpackage

// File: rtl/curkey_match.sv
module curkey_match #(
   parameter int unsigned PIX_W = 24
) (
   input  logic [PIX_W-1:0] pix,
   input  logic [PIX_W-1:0] key,
   input  logic [PIX_W-1:0] mask,
   output logic             hit
);
   logic [PIX_W-1:0] diff;

   for (genvar i = 0; i < PIX_W; i++) begin : g_bit
      assign diff[i] = (pix[i] ^ key[i]) & mask[i];
   end

   assign hit = (diff == '0);
endmodule

// File: rtl/curkey_bitpick.sv
module curkey_bitpick #(
   parameter int unsigned PIX_W = 24,
   parameter int unsigned SEL_W = 5
) (
   input  logic [PIX_W-1:0] pix,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_val
);
   localparam int unsigned SPAN = 1 << SEL_W;

   initial begin
      if (SEL_W < 1 || SEL_W > 16)
         $error("curkey_bitpick: SEL_W out of range");
   end

   generate
      if (SPAN > PIX_W) begin : g_guarded
         // The index can point past the top bit; such values read as 0.
         logic [SPAN-1:0] padded;
         assign padded  = {{(SPAN-PIX_W){1'b0}}, pix};
         assign bit_val = padded[sel];
      end else begin : g_direct
         // Every index value is in range.
         assign bit_val = pix[sel];
      end
   endgenerate
endmodule

// File: rtl/curkey_subst.sv
module curkey_subst
   import curkey_pkg::*;
#(
   parameter int unsigned PIX_W = PIX_W_DEF,
   parameter int unsigned SEL_W = SEL_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PIX_W-1:0] pix_in,
   input  logic             pix_in_vld,
   input  logic [PIX_W-1:0] key_val,
   input  logic [PIX_W-1:0] key_mask,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic [PIX_W-1:0] color_a,
   input  logic [PIX_W-1:0] color_b,
   output logic [PIX_W-1:0] pix_out,
   output logic             pix_out_vld
);
   initial begin
      if (PIX_W < 1 || PIX_W > 64)
         $error("curkey_subst: PIX_W out of range");
   end

   logic     hit;
   logic     pick;
   src_sel_e src;
   logic [PIX_W-1:0] nxt_pix;

   curkey_match #(.PIX_W(PIX_W)) u_match (
      .pix  (pix_in),
      .key  (key_val),
      .mask (key_mask),
      .hit  (hit)
   );

   curkey_bitpick #(.PIX_W(PIX_W), .SEL_W(SEL_W)) u_pick (
      .pix     (pix_in),
      .sel     (bit_sel),
      .bit_val (pick)
   );

   always_comb begin
      if (!hit)      src = SRC_PASS;
      else if (pick) src = SRC_COL_B;
      else           src = SRC_COL_A;
   end

   always_comb begin
      unique case (src)
         SRC_COL_A: nxt_pix = color_a;
         SRC_COL_B: nxt_pix = color_b;
         default:   nxt_pix = pix_in;
      endcase
      if (!pix_in_vld) nxt_pix = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pix_out     <= '0;
         pix_out_vld <= 1'b0;
      end else begin
         pix_out     <= nxt_pix;
         pix_out_vld <= pix_in_vld;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (pix_out == '0 && !pix_out_vld));
   // R2
   vld_delay_chk: assert property (@(posedge clk) disable iff (rst) pix_out_vld == $past(pix_in_vld) || $past(rst));
   // R4
   pass_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_in_vld && ((pix_in ^ key_val) & key_mask) != '0) |=> pix_out == $past(pix_in));
   // R6
   col_a_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_in_vld && ((pix_in ^ key_val) & key_mask) == '0 && (bit_sel < PIX_W) && !pix_in[bit_sel])
      |=> pix_out == $past(color_a));
   // R7
   oor_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_in_vld && ((pix_in ^ key_val) & key_mask) == '0 && (bit_sel >= PIX_W))
      |=> pix_out == $past(color_a));
   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !pix_in_vld |=> pix_out == '0);
endmodule

// File: tb/curkey_subst_bench.sv
module curkey_subst_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic [23:0] pix_in, key_val, key_mask, color_a, color_b;
   logic        pix_in_vld;
   logic [4:0]  bit_sel;
   logic [23:0] pix_out;
   logic        pix_out_vld;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   curkey_subst u_curkey_subst (
      .clk(clk), .rst(rst), .pix_in(pix_in), .pix_in_vld(pix_in_vld),
      .key_val(key_val), .key_mask(key_mask), .bit_sel(bit_sel),
      .color_a(color_a), .color_b(color_b),
      .pix_out(pix_out), .pix_out_vld(pix_out_vld)
   );

   // Fields: pix, key, mask, sel, expected
   typedef struct packed {
      logic [23:0] pix;
      logic [23:0] key;
      logic [23:0] mask;
      logic [4:0]  sel;
      logic [23:0] exp;
   } vec_t;

   localparam logic [23:0] CA = 24'hA1A2A3;
   localparam logic [23:0] CB = 24'hB1B2B3;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{24'h123456, 24'h123456, 24'hFFFFFF, 5'd0,  CA},        // R3 R6 exact, bit0=0
      '{24'h123457, 24'h123457, 24'hFFFFFF, 5'd0,  CB},        // R6 bit0=1
      '{24'h123456, 24'h123457, 24'hFFFFFF, 5'd0,  24'h123456},// R4 miss
      '{24'h12FF56, 24'h120056, 24'hFF00FF, 5'd1,  CB},        // R5 masked middle, bit1=1
      '{24'h12FF56, 24'h130056, 24'hFF00FF, 5'd1,  24'h12FF56},// R4 miss outside mask
      '{24'h000000, 24'hFFFFFF, 24'h000000, 5'd3,  CA},        // R5 zero mask
      '{24'h800000, 24'h000000, 24'h000000, 5'd23, CB},        // R6 top bit
      '{24'h7FFFFF, 24'h000000, 24'h000000, 5'd23, CA},        // R6 top bit clear
      '{24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 5'd24, CA},        // R7 sel 24
      '{24'hFFFFFF, 24'h000000, 24'h000000, 5'd31, CA},        // R7 sel 31
      '{24'h001000, 24'h001000, 24'h00F000, 5'd12, CB},        // R6 middle bit
      '{24'h00F000, 24'h001000, 24'h00F000, 5'd12, 24'h00F000} // R4 miss
   };

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1; pix_in = '0; pix_in_vld = 0; key_val = '0; key_mask = '0;
      bit_sel = '0; color_a = CA; color_b = CB;
      @(posedge clk); @(posedge clk); #2;
      check("R1 pix", pix_out, 24'h0);
      check("R1 vld", {23'h0, pix_out_vld}, 24'h1 & 24'h0);
      @(negedge clk); rst = 0;

      for (int i = 0; i < NV; i++) begin
         pix_in = VECS[i].pix; key_val = VECS[i].key; key_mask = VECS[i].mask;
         bit_sel = VECS[i].sel; pix_in_vld = 1;
         @(posedge clk); #2;
         check($sformatf("R3/R4/R6 vec %0d", i), pix_out, VECS[i].exp);
         check("R2 vld high", {23'h0, pix_out_vld}, 24'h1);
         @(negedge clk);
      end

      // R8: matching pixel without valid
      pix_in = 24'h0; key_val = 24'h0; key_mask = 24'hFFFFFF; pix_in_vld = 0;
      @(posedge clk); #2;
      check("R8 idle pix", pix_out, 24'h0);
      check("R2 vld low", {23'h0, pix_out_vld}, 24'h0);
      @(negedge clk);

      // R1: reset mid-stream
      pix_in_vld = 1; pix_in = 24'h555555; key_val = 24'h0;
      @(posedge clk); #2;
      check("R4 pre-reset", pix_out, 24'h555555);
      @(negedge clk); rst = 1;
      @(posedge clk); #2;
      check("R1 mid pix", pix_out, 24'h0);
      check("R1 mid vld", {23'h0, pix_out_vld}, 24'h0);
      @(negedge clk); rst = 0;
      @(posedge clk); #2;
      check("R2 after reset", {23'h0, pix_out_vld}, 24'h1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule